// File: doc/BRIEF.md
# Rail Setpoint Ramp Generator

This block drives the digital setpoint code of one regulator rail's reference DAC. One code step is 1 mV. When the rail is told to run, the code climbs from zero toward the rail's target at a fast soft-start slope. Once it has reached the target, the rail can switch between two programmable voltages while it runs. That move uses a slower slope, so the output voltage changes gently.

Slopes advance on a one-cycle microsecond tick supplied from outside. Each tick moves the code by one slope step. On the last step the code stops exactly on the target. The voltage-select input may be asynchronous, so it passes through a two-flop synchronizer before it is used. A build-time parameter turns the block into a fixed-voltage rail that ignores the select input. A "done" flag tells downstream logic when the code is at its target.

Top module: `ramp_ref_gen`

## Requirements
- R1: While reset is asserted and right after it, the setpoint code is 0 and done is low.
- R2: In soft-start, each tick while running moves the code by SOFT_STEP (default 18) toward the target. Without a tick the code holds.
- R3: On a rail with selection, select low (0) gives a target of TGT_LO (default 1800) and select high (1) gives TGT_HI (default 2650).
- R4: After the code first reaches its target, a change of target makes the code move at MOVE_STEP (default 10) per tick. It moves up or down as needed.
- R5: The last step of any ramp lands exactly on the target and never passes it.
- R6: When run is low, the code is 0 after the next clock edge. A later run restarts the ramp from 0 at the soft-start slope.
- R7: Done is high exactly while the block is running and the code equals the current target. Done drops in the same cycle the target changes.
- R8: The select input passes through two flops. A change seen at one edge alters the target only after the second edge.
- R9: With HAS_SEL = 0 the target is TGT_FIX (for example 1200), and the select input has no effect on the code or on done.
- R10: A select change during soft-start redirects the ramp to the new target at the soft-start slope.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| run_i | input | 1 | Run command for the rail |
| vsel_i | input | 1 | Voltage select, asynchronous (0 = low target, 1 = high target) |
| tick_i | input | 1 | One-cycle pulse, once per microsecond |
| code_o | output | CODE_W | Setpoint code, 1 mV per step |
| done_o | output | 1 | Code equals the current target while running |

## Verification
The assertions assume that run_i and tick_i are synchronous to clk_i and stable between edges, and that tick_i is a single-cycle pulse. The bench therefore changes run_i, tick_i and vsel_i only on falling edges, and it issues a tick every fourth cycle. The assertions also assume that the targets fit in CODE_W bits and are above zero. The parameters the bench uses meet this.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SOFT = 2'd1,
    PH_MOVE = 2'd2
  } ramp_phase_e;
endpackage

// File: rtl/ramp_sel_sync.sv
module ramp_sel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q[0] <= 1'b0;
    else         chain_q[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[i] <= 1'b0;
      else         chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ramp_target.sv
module ramp_target #(
  parameter int CODE_W  = 12,
  parameter bit HAS_SEL = 1'b1,
  parameter int TGT_LO  = 1800,
  parameter int TGT_HI  = 2650,
  parameter int TGT_FIX = 3300
) (
  input  logic              sel_i,
  output logic [CODE_W-1:0] tgt_o
);
  if (HAS_SEL) begin : g_sel
    assign tgt_o = sel_i ? CODE_W'(TGT_HI) : CODE_W'(TGT_LO);
  end else begin : g_fix
    logic unused_sel;
    assign unused_sel = sel_i;
    assign tgt_o = CODE_W'(TGT_FIX);
  end
endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper
  import ramp_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int SOFT_STEP = 18,
  parameter int MOVE_STEP = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] tgt_i,
  output logic [CODE_W-1:0] code_o,
  output ramp_phase_e       phase_o,
  output logic              done_o
);
  localparam logic [CODE_W-1:0] SoftInc = CODE_W'(SOFT_STEP);
  localparam logic [CODE_W-1:0] MoveInc = CODE_W'(MOVE_STEP);

  logic [CODE_W-1:0] code_q, code_d, inc, gap;
  ramp_phase_e       ph_q, ph_d;
  logic              step_en;

  assign step_en = run_i && tick_i && (ph_q != PH_IDLE);
  assign inc     = (ph_q == PH_SOFT) ? SoftInc : MoveInc;

  always_comb begin
    code_d = code_q;
    ph_d   = ph_q;
    gap    = '0;
    if (!run_i) begin
      code_d = '0;
      ph_d   = PH_IDLE;
    end else if (ph_q == PH_IDLE) begin
      ph_d = PH_SOFT;
    end else begin
      if (step_en) begin
        if (code_q < tgt_i) begin
          gap    = tgt_i - code_q;
          code_d = (gap <= inc) ? tgt_i : code_q + inc;
        end else if (code_q > tgt_i) begin
          gap    = code_q - tgt_i;
          code_d = (gap <= inc) ? tgt_i : code_q - inc;
        end
      end
      if (ph_q == PH_SOFT && code_d == tgt_i) ph_d = PH_MOVE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      ph_q   <= PH_IDLE;
    end else begin
      code_q <= code_d;
      ph_q   <= ph_d;
    end
  end

  assign code_o  = code_q;
  assign phase_o = ph_q;
  assign done_o  = (ph_q != PH_IDLE) && (code_q == tgt_i);
endmodule

// File: rtl/ramp_ref_gen.sv
module ramp_ref_gen
  import ramp_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter bit HAS_SEL   = 1'b1,
  parameter int TGT_LO    = 1800,
  parameter int TGT_HI    = 2650,
  parameter int TGT_FIX   = 3300,
  parameter int SOFT_STEP = 18,
  parameter int MOVE_STEP = 10,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              vsel_i,
  input  logic              tick_i,
  output logic [CODE_W-1:0] code_o,
  output logic              done_o
);
  logic              sel_s;
  logic [CODE_W-1:0] tgt_w;
  ramp_phase_e       phase_w;

  ramp_sel_sync #(.STAGES(SYNC_LEN)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(vsel_i), .q_o(sel_s)
  );

  ramp_target #(
    .CODE_W(CODE_W), .HAS_SEL(HAS_SEL),
    .TGT_LO(TGT_LO), .TGT_HI(TGT_HI), .TGT_FIX(TGT_FIX)
  ) u_tgt (
    .sel_i(sel_s), .tgt_o(tgt_w)
  );

  ramp_stepper #(
    .CODE_W(CODE_W), .SOFT_STEP(SOFT_STEP), .MOVE_STEP(MOVE_STEP)
  ) u_step (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .tick_i(tick_i),
    .tgt_i(tgt_w), .code_o(code_o), .phase_o(phase_w), .done_o(done_o)
  );
endmodule

// File: rtl/ramp_ref_chk.sv
module ramp_ref_chk
  import ramp_pkg::*;
#(
  parameter int CODE_W    = 12,
  parameter int MOVE_STEP = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              tick_i,
  input logic [CODE_W-1:0] code_o,
  input logic              done_o,
  input logic [CODE_W-1:0] tgt_w,
  input ramp_phase_e       phase_w
);
  // R2: no tick while running, code holds
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i) |=> $stable(code_o));

  // R6: run low clears code at the next edge
  p_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (code_o == '0));

  // R4: step size in the move phase is bounded
  p_move_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && phase_w == PH_MOVE) |=>
      (((int'(code_o) >= int'($past(code_o))) ?
        (int'(code_o) - int'($past(code_o))) :
        (int'($past(code_o)) - int'(code_o))) <= MOVE_STEP));

  // R5: ramp from below never passes the target
  p_no_over_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && code_o <= tgt_w) |=> (code_o <= $past(tgt_w)));

  // R5: ramp from above never passes the target
  p_no_over_dn_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && code_o >= tgt_w && phase_w != PH_IDLE) |=> (code_o >= $past(tgt_w)));

  // R7: done stays high while running unless the target moves
  p_done_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && run_i) |=> (done_o || !$stable(tgt_w)));
endmodule

bind ramp_ref_gen ramp_ref_chk #(.CODE_W(CODE_W), .MOVE_STEP(MOVE_STEP)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .tick_i(tick_i),
  .code_o(code_o), .done_o(done_o), .tgt_w(tgt_w), .phase_w(phase_w)
);

// File: tb/ramp_ref_gen_test.sv
`timescale 1ns/1ps
module ramp_ref_gen_test;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n, run, vsel, tick;
  logic [CW-1:0] code, code_f;
  logic done, done_f;

  always #2.5 clk = ~clk;

  ramp_ref_gen #(.CODE_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .vsel_i(vsel), .tick_i(tick),
    .code_o(code), .done_o(done)
  );

  ramp_ref_gen #(.CODE_W(CW), .HAS_SEL(1'b0), .TGT_FIX(1200)) uut_fix (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .vsel_i(vsel), .tick_i(tick),
    .code_o(code_f), .done_o(done_f)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model (main instance)
  int m_code, m_ph, s1, s2;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_code = 0; m_ph = 0; s1 = 0; s2 = 0;
    end else begin
      int tgt, st;
      tgt = s2 ? 2650 : 1800;
      if (!run) begin
        m_code = 0; m_ph = 0;
      end else if (m_ph == 0) begin
        m_ph = 1;
      end else begin
        if (tick) begin
          st = (m_ph == 1) ? 18 : 10;
          if (m_code < tgt)      m_code = (tgt - m_code <= st) ? tgt : m_code + st;
          else if (m_code > tgt) m_code = (m_code - tgt <= st) ? tgt : m_code - st;
        end
        if (m_ph == 1 && m_code == tgt) m_ph = 2;
      end
      s2 = s1; s1 = int'(vsel);
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int etgt;
      etgt = s2 ? 2650 : 1800;
      case (m_ph)
        1:       check("R2 soft-start code", int'(code), m_code);
        2:       check("R4 move code", int'(code), m_code);
        default: check("R6 idle code", int'(code), m_code);
      endcase
      check("R7 done flag", int'(done), (m_ph != 0 && m_code == etgt) ? 1 : 0);
    end
  end

  // tick every fourth cycle
  initial begin
    tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; run = 1'b0; vsel = 1'b0;
    cyc(3);
    check("R1 reset code", int'(code), 0);
    check("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    cyc(2);
    check("R1 post-reset code", int'(code), 0);

    run = 1'b1;
    cyc(800);
    check("R3 low target", int'(code), 1800);
    check("R3 low done", int'(done), 1);

    vsel = 1'b1;
    cyc(1);
    check("R8 one edge, done kept", int'(done), 1);
    cyc(1);
    check("R8 two edges, done dropped", int'(done), 0);
    cyc(800);
    check("R3 high target", int'(code), 2650);
    check("R4 moved up, done", int'(done), 1);

    vsel = 1'b0;
    cyc(800);
    check("R4 moved down", int'(code), 1800);

    run = 1'b0;
    cyc(1);
    check("R6 cleared", int'(code), 0);
    check("R6 done low", int'(done), 0);

    vsel = 1'b1;
    cyc(4);
    run = 1'b1;
    cyc(800);
    check("R5 clamped at 2650", int'(code), 2650);

    run = 1'b0;
    vsel = 1'b0;
    cyc(4);
    run = 1'b1;
    cyc(120);
    vsel = 1'b1;
    cyc(800);
    check("R10 redirected soft-start", int'(code), 2650);

    check("R9 fixed target", int'(code_f), 1200);
    check("R9 fixed done", int'(done_f), 1);
    vsel = 1'b0;
    cyc(40);
    check("R9 select ignored code", int'(code_f), 1200);
    check("R9 select ignored done", int'(done_f), 1);

    finish_run();
  end
endmodule